// File: doc/BRIEF.md
# SPI Slave Memory Bridge with Access Gating

This block is an SPI slave that lets an external host read and write a unified byte address space. The space holds 32768 bytes of local RAM followed by 128 bytes of register storage. A host transfer starts when chip select goes low. The first byte is a command, the next two bytes give a 16-bit start address, and every byte after that is data. Within one chip-select window the address steps forward by one per data byte, so a single transfer can move any number of bytes. Register bytes and RAM bytes take exactly the same serial timing, and so do reads and writes.

The block runs entirely on the system clock. SCK, chip select and SI pass through synchronisers and are sampled there. Because of this, the SCK half period must be at least 8 system clock cycles. The block captures SI on the rising SCK edge and updates SO after the falling edge. Data moves most significant bit first. A host may idle SCK low (mode 0) or high (mode 3). Nothing has to be configured to choose between them.

The RAM and the register file sit outside the block. Each has its own write and read strobe on a shared address and write-data bus, and each returns read data one clock after its read strobe. Until the device reports either a ready condition or a safe-mode condition, host writes are dropped and every read byte carries the master status value.

Top module: `spi_mem_bridge`

## Requirements
- R1: The address map is as follows. Addresses 0x0000 to 0x7FFF access RAM at `acc_addr` equal to the address. Addresses 0x8000 to 0x807F access registers at `acc_addr` equal to the address minus 0x8000. For addresses above 0x807F, writes are dropped and reads return 0x00.
- R2: SI is sampled on rising SCK edges and SO changes only after falling SCK edges. Mode 0 (SCK idle low) and mode 3 (SCK idle high) both work, with no setting.
- R3: Bytes are MSB first. The first byte is the command: 0x01 means write and 0x02 means read. The address high byte and then the address low byte follow. With any other command the rest of the transfer causes no strobe, and SO stays 0.
- R4: Each data byte of a burst advances the address by one. After address 0x807F the next address is 0x0000.
- R5: If chip select rises before all 8 bits of a byte have arrived, that partial byte is discarded and produces no write.
- R6: While `ready_i` and `safe_i` are both low, no write strobe is issued, and every read data byte equals `status_i`. Either flag alone enables access.
- R7: The MSB of the first read byte appears on SO after the first falling SCK edge that follows the last address bit. SI activity during a read changes nothing.
- R8: `spi_so_en` is low whenever `spi_cs_n` is high, so the pad can tri-state SO.
- R9: Every complete data byte of a permitted in-range write produces exactly one single-cycle `ram_we` or `reg_we`, with `wdata` equal to the byte. At most one strobe is active in any cycle.
- R10: After reset, all strobes are low and `spi_so_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data from host |
| spi_so | output | 1 | Serial data to host |
| spi_so_en | output | 1 | Output enable for the SO pad, high while selected |
| ready_i | input | 1 | Device ready flag |
| safe_i | input | 1 | Safe-mode flag |
| status_i | input | 8 | Master status byte returned while access is blocked |
| acc_addr | output | 15 | RAM byte address or register offset |
| wdata | output | 8 | Write data |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_rdata | input | 8 | RAM read data, valid one clock after `ram_re` |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Register read data, valid one clock after `reg_re` |

## Verification
Embedded assertions check on every cycle the following properties:
- At most one storage strobe is active.
- Register accesses stay inside the 128-byte window.
- A write strobe is issued only after a complete byte, and only when the gate was open.
- SO stays still except after a detected falling SCK edge.

Only the directed scenarios can show the byte-level behaviour:
- Data round trips correctly in both SPI modes.
- The burst address wraps from the last register back to RAM address 0.
- A truncated byte is dropped.
- Blocked reads return the status value.
- Out-of-range and unknown-command transfers are harmless.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_WRITE = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_READ  = 8'h02;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_AHI,
    PH_ALO,
    PH_DATA,
    PH_SKIP
  } phase_t;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_RAM,
    SRC_REG,
    SRC_STAT,
    SRC_ZERO
  } rsrc_t;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/smb_shifter.sv
module smb_shifter
  import smb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              si_s,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              so_bit
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              sck_p;
  logic              rise, fall;
  logic [CNT_W-1:0]  bit_cnt, bit_cnt_n;
  logic [BYTE_W-1:0] rx_sh, rx_sh_n;
  logic [BYTE_W-1:0] tx_sh, tx_sh_n;
  logic              so_n, done_n;

  assign rise = sck_s & ~sck_p & ~cs_n_s;
  assign fall = ~sck_s & sck_p & ~cs_n_s;

  always_comb begin
    bit_cnt_n = bit_cnt;
    rx_sh_n   = rx_sh;
    tx_sh_n   = tx_sh;
    so_n      = so_bit;
    done_n    = 1'b0;
    if (cs_n_s) begin
      bit_cnt_n = '0;
      tx_sh_n   = '0;
      so_n      = 1'b0;
    end else if (rise) begin
      rx_sh_n   = {rx_sh[BYTE_W-2:0], si_s};
      bit_cnt_n = bit_cnt + 1'b1;
      done_n    = (bit_cnt == LAST_BIT);
    end else if (fall) begin
      if (bit_cnt == '0) begin
        so_n    = tx_byte[BYTE_W-1];
        tx_sh_n = {tx_byte[BYTE_W-2:0], 1'b0};
      end else begin
        so_n    = tx_sh[BYTE_W-1];
        tx_sh_n = {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p     <= 1'b0;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      so_bit    <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      sck_p     <= sck_s;
      bit_cnt   <= bit_cnt_n;
      rx_sh     <= rx_sh_n;
      tx_sh     <= tx_sh_n;
      so_bit    <= so_n;
      byte_done <= done_n;
    end
  end

  assign rx_byte = rx_sh;

  // R5: a finished byte always comes from a selected frame
  assert_done_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(!cs_n_s));

  // R2: SO moves only after a falling SCK edge while selected
  assert_so_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_s && !fall) |=> $stable(so_bit));
endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int RAM_AW = 15,
  parameter int REG_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              ready_i,
  input  logic              safe_i,
  input  logic [BYTE_W-1:0] status_i,
  input  logic [BYTE_W-1:0] ram_rdata,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [RAM_AW-1:0] acc_addr,
  output logic [BYTE_W-1:0] wdata,
  output logic              ram_we,
  output logic              ram_re,
  output logic              reg_we,
  output logic              reg_re
);
  localparam int RAM_BYTES = 1 << RAM_AW;
  localparam int REG_BYTES = 1 << REG_AW;
  localparam int LAST_LOC  = RAM_BYTES + REG_BYTES - 1;
  localparam logic [ADDR_W-1:0] RAM_END  = ADDR_W'(RAM_BYTES);
  localparam logic [ADDR_W-1:0] SPACE_END = ADDR_W'(LAST_LOC + 1);
  localparam logic [ADDR_W-1:0] LAST_A   = ADDR_W'(LAST_LOC);

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return (a == LAST_A) ? '0 : a + 1'b1;
  endfunction

  phase_t              phase, phase_n;
  logic                op_rd, op_rd_n;
  logic [ADDR_W-1:0]   addr, addr_n;
  logic [BYTE_W-1:0]   addr_hi, addr_hi_n;
  logic [RAM_AW-1:0]   acc_n;
  logic [BYTE_W-1:0]   wdata_n, tx_n;
  logic                ram_we_n, ram_re_n, reg_we_n, reg_re_n;
  rsrc_t               rsrc1, rsrc1_n, rsrc2, rsrc2_n;
  logic [ADDR_W-1:0]   tgt;
  logic                do_rd, do_wr, gate_ok, in_ram, in_reg;

  assign gate_ok = ready_i | safe_i;
  assign in_ram  = (tgt < RAM_END);
  assign in_reg  = !in_ram && (tgt < SPACE_END);

  always_comb begin
    phase_n   = phase;
    op_rd_n   = op_rd;
    addr_n    = addr;
    addr_hi_n = addr_hi;
    acc_n     = acc_addr;
    wdata_n   = wdata;
    ram_we_n  = 1'b0;
    ram_re_n  = 1'b0;
    reg_we_n  = 1'b0;
    reg_re_n  = 1'b0;
    rsrc1_n   = SRC_NONE;
    rsrc2_n   = rsrc1;
    tx_n      = tx_byte;
    tgt       = addr;
    do_rd     = 1'b0;
    do_wr     = 1'b0;

    case (rsrc2)
      SRC_RAM:  tx_n = ram_rdata;
      SRC_REG:  tx_n = reg_rdata;
      SRC_STAT: tx_n = status_i;
      SRC_ZERO: tx_n = '0;
      default:  tx_n = tx_byte;
    endcase

    if (cs_n_s) begin
      phase_n = PH_CMD;
      rsrc1_n = SRC_NONE;
      rsrc2_n = SRC_NONE;
      tx_n    = '0;
    end else if (byte_done) begin
      case (phase)
        PH_CMD: begin
          if (rx_byte == CMD_WRITE) begin
            op_rd_n = 1'b0;
            phase_n = PH_AHI;
          end else if (rx_byte == CMD_READ) begin
            op_rd_n = 1'b1;
            phase_n = PH_AHI;
          end else begin
            phase_n = PH_SKIP;
          end
        end
        PH_AHI: begin
          addr_hi_n = rx_byte;
          phase_n   = PH_ALO;
        end
        PH_ALO: begin
          addr_n  = {addr_hi, rx_byte};
          tgt     = {addr_hi, rx_byte};
          do_rd   = op_rd;
          phase_n = PH_DATA;
        end
        PH_DATA: begin
          addr_n = step_addr(addr);
          if (op_rd) begin
            tgt   = step_addr(addr);
            do_rd = 1'b1;
          end else begin
            tgt   = addr;
            do_wr = 1'b1;
          end
        end
        default: phase_n = PH_SKIP;
      endcase
    end

    if (do_wr && gate_ok && (in_ram || in_reg)) begin
      ram_we_n = in_ram;
      reg_we_n = in_reg;
      wdata_n  = rx_byte;
      acc_n    = in_ram ? tgt[RAM_AW-1:0]
                        : {{(RAM_AW-REG_AW){1'b0}}, tgt[REG_AW-1:0]};
    end

    if (do_rd) begin
      if (!gate_ok) begin
        rsrc1_n = SRC_STAT;
      end else if (in_ram) begin
        ram_re_n = 1'b1;
        rsrc1_n  = SRC_RAM;
        acc_n    = tgt[RAM_AW-1:0];
      end else if (in_reg) begin
        reg_re_n = 1'b1;
        rsrc1_n  = SRC_REG;
        acc_n    = {{(RAM_AW-REG_AW){1'b0}}, tgt[REG_AW-1:0]};
      end else begin
        rsrc1_n = SRC_ZERO;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      op_rd    <= 1'b0;
      addr     <= '0;
      addr_hi  <= '0;
      acc_addr <= '0;
      wdata    <= '0;
      ram_we   <= 1'b0;
      ram_re   <= 1'b0;
      reg_we   <= 1'b0;
      reg_re   <= 1'b0;
      rsrc1    <= SRC_NONE;
      rsrc2    <= SRC_NONE;
      tx_byte  <= '0;
    end else begin
      phase    <= phase_n;
      op_rd    <= op_rd_n;
      addr     <= addr_n;
      addr_hi  <= addr_hi_n;
      acc_addr <= acc_n;
      wdata    <= wdata_n;
      ram_we   <= ram_we_n;
      ram_re   <= ram_re_n;
      reg_we   <= reg_we_n;
      reg_re   <= reg_re_n;
      rsrc1    <= rsrc1_n;
      rsrc2    <= rsrc2_n;
      tx_byte  <= tx_n;
    end
  end

  // R9: never more than one storage strobe in a cycle
  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we, ram_re, reg_we, reg_re}));

  // R6: a write strobe needs the gate open when its byte completed
  assert_gate_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || reg_we) |-> $past(ready_i || safe_i));

  // R1: register accesses stay within the register window
  assert_reg_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || reg_re) |-> (acc_addr < RAM_AW'(REG_BYTES)));

  // R5: writes only follow a completed byte
  assert_write_after_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || reg_we) |-> $past(byte_done));
endmodule

// File: rtl/spi_mem_bridge.sv
module spi_mem_bridge
  import smb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int RAM_AW = 15,
  parameter int REG_AW = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_en,
  input  logic              ready_i,
  input  logic              safe_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic [RAM_AW-1:0] acc_addr,
  output logic [BYTE_W-1:0] wdata,
  output logic              ram_we,
  output logic              ram_re,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [2:0]        pins_s;
  logic              byte_done, so_bit;
  logic [BYTE_W-1:0] rx_byte, tx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  smb_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({spi_sck, spi_cs_n, spi_si}),
    .q     (pins_s)
  );

  smb_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sck_s     (pins_s[2]),
    .cs_n_s    (pins_s[1]),
    .si_s      (pins_s[0]),
    .tx_byte   (tx_byte),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .so_bit    (so_bit)
  );

  smb_ctrl #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .REG_AW(REG_AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cs_n_s    (pins_s[1]),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .ready_i   (ready_i),
    .safe_i    (safe_i),
    .status_i  (status_i),
    .ram_rdata (ram_rdata),
    .reg_rdata (reg_rdata),
    .tx_byte   (tx_byte),
    .acc_addr  (acc_addr),
    .wdata     (wdata),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .reg_we    (reg_we),
    .reg_re    (reg_re)
  );

  assign spi_so    = so_bit;
  assign spi_so_en = ~spi_cs_n;
endmodule

// File: tb/spi_mem_bridge_tb.sv
module spi_mem_bridge_tb;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_en;
  logic ready = 1'b1, safe = 1'b0;
  logic [7:0] status = 8'hA7;
  logic [14:0] acc_addr;
  logic [7:0] wdata, ram_rdata, reg_rdata;
  logic ram_we, ram_re, reg_we, reg_re;

  logic [7:0] ram_m [32768];
  logic [7:0] reg_m [128];
  int wr_cnt = 0;
  int checks = 0, fails = 0;
  bit m3 = 1'b0;
  bit done = 1'b0;
  logic [7:0] tbuf [8];
  logic [7:0] rbuf [8];

  always #2 clk = ~clk;

  spi_mem_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_so(so), .spi_so_en(so_en), .ready_i(ready), .safe_i(safe),
    .status_i(status), .acc_addr(acc_addr), .wdata(wdata),
    .ram_we(ram_we), .ram_re(ram_re), .ram_rdata(ram_rdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (ram_we) begin ram_m[acc_addr] <= wdata; wr_cnt <= wr_cnt + 1; end
    if (reg_we) begin reg_m[acc_addr[6:0]] <= wdata; wr_cnt <= wr_cnt + 1; end
    if (ram_re) ram_rdata <= ram_m[acc_addr];
    if (reg_re) reg_rdata <= reg_m[acc_addr[6:0]];
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_start();
    sck = m3;
    wclk(3);
    cs_n = 1'b0;
    wclk(HALF);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nb; i--) begin
      sck = 1'b0;
      si = tx[i];
      wclk(HALF);
      sck = 1'b1;
      rx[i] = so;
      wclk(HALF);
    end
  endtask

  task automatic spi_stop();
    if (!m3) begin
      sck = 1'b0;
      wclk(HALF);
    end
    cs_n = 1'b1;
    wclk(2 * HALF + 6);
  endtask

  task automatic xfer(input int n);
    logic [7:0] r;
    spi_start();
    for (int k = 0; k < n; k++) begin
      spi_bits(tbuf[k], 8, r);
      rbuf[k] = r;
    end
    spi_stop();
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input logic [7:0] d0,
                          input logic [7:0] d1, input logic [7:0] d2);
    tbuf[0] = 8'h01; tbuf[1] = a[15:8]; tbuf[2] = a[7:0];
    tbuf[3] = d0; tbuf[4] = d1; tbuf[5] = d2;
    xfer(3 + n);
  endtask

  task automatic do_read(input logic [15:0] a, input int n, input logic [7:0] fill);
    tbuf[0] = 8'h02; tbuf[1] = a[15:8]; tbuf[2] = a[7:0];
    for (int k = 3; k < 8; k++) tbuf[k] = fill ^ 8'(k);
    xfer(3 + n);
  endtask

  task automatic t_reset();
    check(so_en == 1'b0, "R10 so_en after reset", so_en, 0);
    check({ram_we, ram_re, reg_we, reg_re} == 4'b0, "R10 strobes after reset",
          {ram_we, ram_re, reg_we, reg_re}, 0);
    check(so_en == 1'b0, "R8 so_en while cs high", so_en, 0);
    cs_n = 1'b0; wclk(2);
    check(so_en == 1'b1, "R8 so_en while selected", so_en, 1);
    cs_n = 1'b1; wclk(HALF);
    check(so_en == 1'b0, "R8 so_en after deselect", so_en, 0);
  endtask

  task automatic t_ram_mode0();
    int w0;
    m3 = 1'b0; w0 = wr_cnt;
    do_write(16'h0100, 3, 8'h3C, 8'hA5, 8'h81);
    check(wr_cnt - w0 == 3, "R9 three write strobes", wr_cnt - w0, 3);
    check(ram_m[15'h0101] == 8'hA5, "R1 RAM byte stored", ram_m[15'h0101], 8'hA5);
    do_read(16'h0100, 3, 8'h00);
    check(rbuf[3] == 8'h3C, "R2 mode0 read byte0", rbuf[3], 8'h3C);
    check(rbuf[4] == 8'hA5, "R4 mode0 read byte1", rbuf[4], 8'hA5);
    check(rbuf[5] == 8'h81, "R7 mode0 read byte2", rbuf[5], 8'h81);
    check(rbuf[0] == 8'h00, "R3 SO idle during command", rbuf[0], 0);
  endtask

  task automatic t_ram_mode3();
    m3 = 1'b1;
    do_write(16'h2345, 2, 8'h5A, 8'hC7, 8'h00);
    check(ram_m[15'h2346] == 8'hC7, "R2 mode3 write stored", ram_m[15'h2346], 8'hC7);
    do_read(16'h2345, 2, 8'h00);
    check(rbuf[3] == 8'h5A && rbuf[4] == 8'hC7, "R2 mode3 read burst",
          {rbuf[3], rbuf[4]}, 16'h5AC7);
    m3 = 1'b0;
  endtask

  task automatic t_si_ignored();
    int w0;
    w0 = wr_cnt;
    do_read(16'h0100, 3, 8'hFF);
    check(wr_cnt == w0, "R7 SI ignored no write", wr_cnt - w0, 0);
    check(rbuf[3] == 8'h3C && rbuf[5] == 8'h81, "R7 read data with SI busy",
          {rbuf[3], rbuf[5]}, 16'h3C81);
  endtask

  task automatic t_register_and_wrap();
    do_write(16'h8005, 1, 8'h96, 8'h00, 8'h00);
    check(reg_m[5] == 8'h96, "R1 register offset 5", reg_m[5], 8'h96);
    m3 = 1'b1;
    do_write(16'h807F, 2, 8'hE1, 8'h1E, 8'h00);
    check(reg_m[127] == 8'hE1, "R4 last register written", reg_m[127], 8'hE1);
    check(ram_m[0] == 8'h1E, "R4 wrap to RAM 0", ram_m[0], 8'h1E);
    do_read(16'h807F, 2, 8'h00);
    check(rbuf[3] == 8'hE1 && rbuf[4] == 8'h1E, "R4 wrap read burst",
          {rbuf[3], rbuf[4]}, 16'hE11E);
    m3 = 1'b0;
    do_read(16'h8005, 1, 8'h00);
    check(rbuf[3] == 8'h96, "R1 register read back", rbuf[3], 8'h96);
  endtask

  task automatic t_partial();
    logic [7:0] r;
    int w0;
    do_write(16'h0301, 1, 8'h66, 8'h00, 8'h00);
    w0 = wr_cnt;
    spi_start();
    spi_bits(8'h01, 8, r); spi_bits(8'h03, 8, r); spi_bits(8'h00, 8, r);
    spi_bits(8'h44, 8, r);
    spi_bits(8'h99, 5, r);
    spi_stop();
    check(wr_cnt - w0 == 1, "R5 only whole byte written", wr_cnt - w0, 1);
    check(ram_m[15'h0301] == 8'h66, "R5 partial byte discarded", ram_m[15'h0301], 8'h66);
    check(ram_m[15'h0300] == 8'h44, "R5 whole byte stored", ram_m[15'h0300], 8'h44);
  endtask

  task automatic t_bad_cmd();
    int w0;
    w0 = wr_cnt;
    tbuf[0] = 8'h55; tbuf[1] = 8'h03; tbuf[2] = 8'h00; tbuf[3] = 8'h77; tbuf[4] = 8'h88;
    xfer(5);
    check(wr_cnt == w0, "R3 unknown command no write", wr_cnt - w0, 0);
    check(rbuf[3] == 8'h00 && rbuf[4] == 8'h00, "R3 unknown command SO zero",
          {rbuf[3], rbuf[4]}, 0);
    check(ram_m[15'h0300] == 8'h44, "R3 RAM untouched", ram_m[15'h0300], 8'h44);
  endtask

  task automatic t_gate();
    int w0;
    do_write(16'h0200, 1, 8'h22, 8'h00, 8'h00);
    ready = 1'b0; safe = 1'b0;
    w0 = wr_cnt;
    do_write(16'h0200, 1, 8'h11, 8'h00, 8'h00);
    check(wr_cnt == w0, "R6 gated write dropped", wr_cnt - w0, 0);
    do_read(16'h0200, 2, 8'h00);
    check(rbuf[3] == 8'hA7 && rbuf[4] == 8'hA7, "R6 gated read returns status",
          {rbuf[3], rbuf[4]}, 16'hA7A7);
    safe = 1'b1;
    do_read(16'h0200, 1, 8'h00);
    check(rbuf[3] == 8'h22, "R6 safe flag opens read", rbuf[3], 8'h22);
    do_write(16'h0200, 1, 8'h33, 8'h00, 8'h00);
    check(ram_m[15'h0200] == 8'h33, "R6 safe flag opens write", ram_m[15'h0200], 8'h33);
    safe = 1'b0; ready = 1'b1;
  endtask

  task automatic t_out_of_range();
    int w0;
    w0 = wr_cnt;
    do_write(16'h9000, 2, 8'h12, 8'h34, 8'h00);
    check(wr_cnt == w0, "R1 out-of-range write dropped", wr_cnt - w0, 0);
    do_read(16'h9000, 2, 8'h00);
    check(rbuf[3] == 8'h00 && rbuf[4] == 8'h00, "R1 out-of-range read zero",
          {rbuf[3], rbuf[4]}, 0);
  endtask

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    t_reset();
    t_ram_mode0();
    t_ram_mode3();
    t_si_ignored();
    t_register_and_wrap();
    t_partial();
    t_bad_cmd();
    t_gate();
    t_out_of_range();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule